// File: doc/BRIEF.md
# PCM Voice Bus Timing and Slot Engine

This block keeps time on a 32-slot serial PCM voice bus and moves the four data slots that the device owns. In master mode it makes the bus bit clock (one bit-clock period per two system clocks), the frame sync and two codec strobes. In slave mode it takes bit clock and frame sync from the bus, locks its frame counter to the sync, and flags any sync that arrives out of place or not at all. A frame holds 512 bit-clock periods. Each data bit lasts two bit-clock periods, so a frame carries 32 slots of 8 bits.

One write-only mode byte sets the mode and the sync and strobe shapes. Four byte registers sit behind the slots B1, B2, AUX1 and AUX2. A read returns the last byte received in that slot. A write sets the byte transmitted from the next frame on. An AUX transmit slot that software did not write in the previous frame echoes what was received in that slot, which lets two codecs on the bus talk through the block.

Top module: `pcm_frame_gen`

## Requirements
- R1: After reset the mode byte is zero: slave, bus pins not driven (bclkOe = fsOe = 0), syncErr = 0, regRdData = 0. The frame position is 0, so fsOut, strobeA and strobeB read 1.
- R2: With mode bit 0 = 1 the block drives bclkOe and fsOe high, and bclkOut toggles on every system clock. Bit-clock period k of a frame spans system cycles 2k and 2k+1, and a frame has 512 periods.
- R3: The frame sync is active in bit-clock period 0, and also in period 1 when mode bit 3 = 1. fsOut equals that activity XOR mode bit 2, so bit 2 = 1 makes the pulse active low.
- R4: Mode bits 5:4 = 0, 1 or 2 place strobeA on the B1, B2 or AUX1 slot (slot numbers are parameters, default 0 to 3). A slot starts at bit-clock period 16×slot, and the strobe has the frame sync's length and polarity.
- R5: Mode bits 5:4 = 3 turn strobeA into a clock at half the bit rate: the LSB of the bit-clock period index XOR mode bit 1.
- R6: Mode bits 7:6 = 0, 1, 2 or 3 place strobeB on B1, B2, AUX1 or AUX2, with the same shape rules as R4.
- R7: rxd is sampled once per data bit, MSB first. The completed byte of each owned slot is readable at address 0 (B1), 1 (B2), 2 (AUX1) or 3 (AUX2). regRdData is valid one cycle after regRdEn and is 0 when no read was made.
- R8: At each frame start the transmit bytes are latched. During an owned slot, txd carries bit 7-i of that slot's latched byte in data bit i and txOe is 1. Elsewhere txd = 1 and txOe = 0. B1 and B2 send the last written value.
- R9: An AUX slot that was not written since the previous frame start transmits the byte received in that slot in the frame just ended.
- R10: The mode byte at address 4 is write-only, and reading it returns 0.
- R11: In slave mode with mode bit 1 = 0, frame sync is sampled on the falling bit-clock edge, and a leading sync edge makes the next bit-clock period position 0.
- R12: In slave mode with mode bit 1 = 1, frame sync is sampled on the rising edge, and the period whose rising edge saw the leading sync edge becomes position 0.
- R13: Once locked to a first sync, a sync that moves the frame start, or a frame end with no sync, sets syncErr. The counter follows the new sync, and syncErr stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Bus bit clock in slave mode |
| fsIn | input | 1 | Bus frame sync in slave mode |
| bclkOut | output | 1 | Generated bit clock |
| bclkOe | output | 1 | Drive enable for the bit clock pin |
| fsOut | output | 1 | Generated frame sync |
| fsOe | output | 1 | Drive enable for the frame sync pin |
| strobeA | output | 1 | Codec A strobe or half-rate clock |
| strobeB | output | 1 | Codec B strobe |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| txOe | output | 1 | High while an owned slot is transmitted |
| regAddr | input | 3 | Register address (0 to 3 slot bytes, 4 mode) |
| regWrData | input | 8 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 8 | Register read data, one cycle after regRdEn |
| syncErr | output | 1 | Sticky slave sync error |

## Verification
In master mode every bus output is a function of the system cycles elapsed since the mode write. The bench checks fs, strobes, bit clock and txd on every falling edge from the cycle right after that write. The frame-start latch is modelled at the first cycle of each frame. Register reads are checked on the falling edge after the capturing rising edge. In slave mode a bench bit lasts eight system clocks: the block sees the rising edge one clock later and updates its position on the clock after that, so the bench samples six clocks into each bit, after both edges have been taken in.

// File: rtl/pcm_frame_pkg.sv
package pcm_frame_pkg;

  localparam logic [2:0] MODE_ADDR = 3'd4;

  typedef struct packed {
    logic [1:0] selB;
    logic [1:0] selA;
    logic       fsLong;
    logic       fsLow;
    logic       edgeRise;
    logic       master;
  } pcmMode_t;

  typedef struct packed {
    logic       bitEnd;
    logic       frameStart;
    logic [3:0] slotHit;
    logic [2:0] bitIdx;
  } pcmStrobe_t;

endpackage

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_frame_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_B1   = 0,
  parameter int SLOT_B2   = 1,
  parameter int SLOT_AUX1 = 2,
  parameter int SLOT_AUX2 = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkIn,
  input  logic       fsIn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  output logic       bclkOut,
  output logic       bclkOe,
  output logic       fsOut,
  output logic       fsOe,
  output logic       strobeA,
  output logic       strobeB,
  output logic       syncErr,
  output pcmStrobe_t stb
);
  localparam int SUB_W      = 4;
  localparam int FRAME_BCLK = SLOTS * (1 << SUB_W);
  localparam int CNT_W      = $clog2(FRAME_BCLK);
  localparam int SLOT_W     = CNT_W - SUB_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BCLK - 1);
  localparam int DSLOT [4] = '{SLOT_B1, SLOT_B2, SLOT_AUX1, SLOT_AUX2};

  pcmMode_t          mode;
  logic              phase;
  logic [CNT_W-1:0]  bitCnt;
  logic              bclkQ, bclkPrev, fsQ, fsPrevSamp, pendSync, locked;
  logic              bclkRise, bclkFall, fsAct, sampEv, lead, adv, syncNow;
  logic              inHead;
  logic [3:0]        slotHit;
  logic [SLOT_W-1:0] slotNum;

  always_ff @(posedge clk) begin
    if (!rstN) mode <= '0;
    else if (wrEn && addr == MODE_ADDR) mode <= pcmMode_t'(wrData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ <= 1'b0; bclkPrev <= 1'b0; fsQ <= 1'b0;
    end else begin
      bclkQ <= bclkIn; bclkPrev <= bclkQ; fsQ <= fsIn;
    end
  end

  assign bclkRise = bclkQ & ~bclkPrev;
  assign bclkFall = ~bclkQ & bclkPrev;
  assign fsAct    = fsQ ^ mode.fsLow;
  assign sampEv   = !mode.master && (mode.edgeRise ? bclkRise : bclkFall);
  assign lead     = sampEv && fsAct && !fsPrevSamp;
  assign adv      = mode.master ? phase : bclkRise;
  assign syncNow  = !mode.master && (mode.edgeRise ? lead : pendSync);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= 1'b0; bitCnt <= '0; fsPrevSamp <= 1'b0;
      pendSync <= 1'b0; locked <= 1'b0; syncErr <= 1'b0;
    end else begin
      phase <= mode.master ? ~phase : 1'b0;
      if (sampEv) fsPrevSamp <= fsAct;
      if (adv) pendSync <= 1'b0;
      else if (lead) pendSync <= 1'b1;
      if (adv) begin
        if (syncNow) begin
          if (locked && bitCnt != LAST) syncErr <= 1'b1;
          bitCnt <= '0;
          locked <= 1'b1;
        end else begin
          if (locked && !mode.master && bitCnt == LAST) syncErr <= 1'b1;
          bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
        end
      end
    end
  end

  assign slotNum = bitCnt[CNT_W-1:SUB_W];
  assign inHead  = (bitCnt[SUB_W-1:0] == '0) ||
                   (mode.fsLong && bitCnt[SUB_W-1:0] == SUB_W'(1));

  for (genvar k = 0; k < 4; k++) begin : g_slot
    assign slotHit[k] = (slotNum == SLOT_W'(DSLOT[k]));
  end

  always_comb begin
    stb.bitEnd     = adv && bitCnt[0];
    stb.frameStart = adv && (syncNow || bitCnt == LAST);
    stb.slotHit    = slotHit;
    stb.bitIdx     = bitCnt[SUB_W-1:1];
    fsOut   = ((bitCnt == '0) || (mode.fsLong && bitCnt == CNT_W'(1))) ^ mode.fsLow;
    strobeA = (mode.selA == 2'd3) ? (bitCnt[0] ^ mode.edgeRise)
                                  : ((slotHit[mode.selA] && inHead) ^ mode.fsLow);
    strobeB = (slotHit[mode.selB] && inHead) ^ mode.fsLow;
    bclkOut = mode.master & phase;
    bclkOe  = mode.master;
    fsOe    = mode.master;
  end

  // R2: in master mode the bit clock changes level on every system clock
  a_r2_bclk_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (mode.master && $past(mode.master)) |-> (bclkOut != $past(bclkOut)));

  // R13: the sync error flag never clears on its own
  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> syncErr);

  // R4: an active slot strobe only appears inside one of the owned slots
  a_r4_strobe_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    (mode.selA != 2'd3 && (strobeA != mode.fsLow)) |-> (stb.slotHit != 4'b0));

  // R11: a pending falling-edge sync is consumed by the next bit-clock advance
  a_r11_pending_used: assert property (@(posedge clk) disable iff (!rstN)
    adv |=> !pendSync);

endmodule

// File: rtl/pcm_frame_dp.sv
module pcm_frame_dp
  import pcm_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pcmStrobe_t stb,
  input  logic       rxd,
  output logic       txd,
  output logic       txOe,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  input  logic       rdEn,
  output logic [7:0] rdData
);
  logic [6:0] rxShift;
  logic [7:0] rxVal [4];
  logic [3:0] bitK;

  always_ff @(posedge clk) begin
    if (!rstN) rxShift <= '0;
    else if (stb.bitEnd) rxShift <= {rxShift[5:0], rxd};
  end

  for (genvar k = 0; k < 4; k++) begin : g_reg
    localparam bit IS_AUX = (k >= 2);
    logic [7:0] rxR, txR, txL;
    logic       wrote;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxR <= '0; txR <= '0; txL <= '0; wrote <= 1'b0;
      end else begin
        if (stb.bitEnd && stb.slotHit[k] && stb.bitIdx == 3'd7)
          rxR <= {rxShift, rxd};
        if (wrEn && addr == 3'(k)) begin
          txR   <= wrData;
          wrote <= 1'b1;
        end else if (stb.frameStart) begin
          wrote <= 1'b0;
        end
        if (stb.frameStart)
          txL <= (IS_AUX && !wrote) ? rxR : txR;
      end
    end

    assign rxVal[k] = rxR;
    assign bitK[k]  = txL[~stb.bitIdx];
  end

  assign txOe = |stb.slotHit;
  assign txd  = txOe ? |(stb.slotHit & bitK) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (rdEn && !addr[2]) rdData <= rxVal[addr[1:0]];
    else rdData <= '0;
  end

  // R8: outside the owned slots the line idles high
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> txd);

  // R7: read data is zero in the cycle after no read was requested
  a_r7_rd_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == 8'd0));

  // R10: a read of the mode address returns zero
  a_r10_mode_unreadable: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == MODE_ADDR) |=> (rdData == 8'd0));

endmodule

// File: rtl/pcm_frame_gen.sv
module pcm_frame_gen
  import pcm_frame_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_B1   = 0,
  parameter int SLOT_B2   = 1,
  parameter int SLOT_AUX1 = 2,
  parameter int SLOT_AUX2 = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkIn,
  input  logic       fsIn,
  output logic       bclkOut,
  output logic       bclkOe,
  output logic       fsOut,
  output logic       fsOe,
  output logic       strobeA,
  output logic       strobeB,
  input  logic       rxd,
  output logic       txd,
  output logic       txOe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       regWrEn,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       syncErr
);
  pcmStrobe_t stb;

  pcm_frame_ctrl #(
    .SLOTS(SLOTS), .SLOT_B1(SLOT_B1), .SLOT_B2(SLOT_B2),
    .SLOT_AUX1(SLOT_AUX1), .SLOT_AUX2(SLOT_AUX2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .fsIn(fsIn),
    .addr(regAddr), .wrData(regWrData), .wrEn(regWrEn),
    .bclkOut(bclkOut), .bclkOe(bclkOe), .fsOut(fsOut), .fsOe(fsOe),
    .strobeA(strobeA), .strobeB(strobeB), .syncErr(syncErr), .stb(stb)
  );

  pcm_frame_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxd(rxd), .txd(txd), .txOe(txOe),
    .addr(regAddr), .wrData(regWrData), .wrEn(regWrEn), .rdEn(regRdEn),
    .rdData(regRdData)
  );

endmodule

// File: tb/pcm_frame_gen_test.sv
module pcm_frame_gen_test;
  logic clk = 1'b0, rstN = 1'b0, bclkIn = 1'b0, fsIn = 1'b0, rxd = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic bclkOut, bclkOe, fsOut, fsOe, strobeA, strobeB, txd, txOe, syncErr;
  logic [7:0] regRdData;

  pcm_frame_gen uut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .fsIn(fsIn),
    .bclkOut(bclkOut), .bclkOe(bclkOe), .fsOut(fsOut), .fsOe(fsOe),
    .strobeA(strobeA), .strobeB(strobeB), .rxd(rxd), .txd(txd), .txOe(txOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData), .syncErr(syncErr)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, cyc0 = 0;
  bit monOn = 0, done = 0;
  logic [7:0] modeExp = '0;
  logic [7:0] txB [4] = '{default: '0};
  logic [7:0] latchB [4] = '{default: '0};
  bit wroteB [4] = '{default: 0};
  int sCnt = 0;
  bit sLocked = 0, sErr = 0, fsP1 = 0, fsP2 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] rxByte(input int f, input int s);
    return 8'((s * 37 + f * 11 + 5) % 256);
  endfunction

  function automatic logic [7:0] cfg(input int i);
    logic [5:0] v;
    v = 6'(i);
    return {v[5:4], v[3:2], v[1], v[0], v[2] ^ v[5], 1'b1};
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    if (a == 3'd4) modeExp = d;
    else begin txB[a[1:0]] = d; wroteB[a[1:0]] = 1; end
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, input logic [7:0] exp, input string req);
    regAddr = a; regRdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regRdEn = 1'b0;
    chk(req, regRdData, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0; bclkIn = 1'b0; fsIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sCnt = 0; sLocked = 0; sErr = 0; fsP1 = 0; fsP2 = 0; modeExp = '0;
    @(negedge clk);
  endtask

  // one slave bit-clock period of eight system clocks
  task automatic slaveBit(input bit fsL, input bit rising, input bit lng,
                          input bit pol, input int slotSel, input string req);
    bit apply, act;
    fsIn = fsL ^ pol; bclkIn = 1'b1;
    repeat (4) @(negedge clk);
    bclkIn = 1'b0;
    repeat (2) @(negedge clk);
    apply = rising ? (fsL && !fsP1) : (fsP1 && !fsP2);
    if (apply) begin
      if (sLocked && sCnt != 511) sErr = 1;
      sCnt = 0; sLocked = 1;
    end else begin
      if (sLocked && sCnt == 511) sErr = 1;
      sCnt = (sCnt + 1) % 512;
    end
    fsP2 = fsP1; fsP1 = fsL;
    act = (sCnt / 16 == slotSel) && ((sCnt % 16 == 0) || (lng && sCnt % 16 == 1));
    chk(req, strobeA, act ^ pol);
    chk("R13 sync error", syncErr, sErr);
    chk("R1 slave pins undriven", {bclkOe, fsOe}, 2'b00);
    repeat (2) @(negedge clk);
  endtask

  // master-mode monitor, one set of checks per system cycle
  always @(negedge clk) begin
    if (monOn) begin
      int n, bc, f, s, b;
      bit lng, pol, er, fsA, hA, hB, expA, expB, expD, expOe;
      logic [7:0] rb;
      n = cyc - cyc0; bc = (n / 2) % 512; f = n / 1024; s = bc / 16; b = (bc % 16) / 2;
      if (n % 1024 == 0 && n > 0) begin
        for (int k = 0; k < 4; k++) begin
          latchB[k] = (k >= 2 && !wroteB[k]) ? rxByte(f - 1, k) : txB[k];
          wroteB[k] = 0;
        end
      end
      rb = rxByte(f, s);
      rxd = rb[7 - b];
      lng = modeExp[3]; pol = modeExp[2]; er = modeExp[1];
      fsA = (bc == 0) || (lng && bc == 1);
      hA = (s == int'(modeExp[5:4])) && ((bc % 16 == 0) || (lng && bc % 16 == 1));
      hB = (s == int'(modeExp[7:6])) && ((bc % 16 == 0) || (lng && bc % 16 == 1));
      chk("R2 bit clock", {bclkOut, bclkOe, fsOe}, {1'(n % 2), 2'b11});
      chk("R3 frame sync", fsOut, fsA ^ pol);
      if (modeExp[5:4] == 2'd3) begin
        expA = 1'((bc % 2)) ^ er;
        chk("R5 half-rate clock", strobeA, expA);
      end else begin
        expA = hA ^ pol;
        chk("R4 codec A strobe", strobeA, expA);
      end
      expB = hB ^ pol;
      chk("R6 codec B strobe", strobeB, expB);
      expOe = (s < 4);
      expD  = expOe ? latchB[s][7 - b] : 1'b1;
      chk(s >= 2 && s < 4 ? "R9 aux transmit" : "R8 transmit", {txOe, txd}, {expOe, expD});
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished run");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state
    chk("R1 reset pin enables", {bclkOe, fsOe}, 2'b00);
    chk("R1 reset sync error", syncErr, 1'b0);
    chk("R1 reset read data", regRdData, 8'h00);
    chk("R1 reset strobes at position 0", {fsOut, strobeA, strobeB}, 3'b111);

    // master sweep over strobe selections, sync shapes and clock edge bit
    writeReg(3'd4, cfg(0));
    cyc0 = cyc;
    monOn = 1;
    for (int i = 0; i < 64; i++) begin
      int f;
      while ((cyc - cyc0) % 1024 != 400) @(negedge clk);
      f = (cyc - cyc0) / 1024;
      writeReg(3'd4, cfg(i));
      writeReg(3'd0, 8'(i * 3 + 1));
      writeReg(3'd1, ~8'(i));
      if (i % 2 == 0) writeReg(3'd2, 8'(i) ^ 8'hA5);
      if (i % 8 == 3) writeReg(3'd3, 8'(i + 100));
      for (int s = 0; s < 4; s++) readReg(3'(s), rxByte(f, s), "R7 receive read");
      readReg(3'd4, 8'h00, "R10 mode write-only");
    end
    monOn = 0;

    // slave, falling-edge sampling, active-high short sync, strobe A on B1
    doReset();
    writeReg(3'd4, 8'h00);
    for (int t = 0; t < 2400; t++) begin
      bit fsL;
      fsL = (t == 0) || (t == 512) || (t == 1024) || (t == 1736) || (t == 2248);
      slaveBit(fsL, 1'b0, 1'b0, 1'b0, 0, "R11 falling-edge lock");
    end
    chk("R13 sticky after misplaced sync", syncErr, 1'b1);

    // slave, rising-edge sampling, active-low long sync, strobe A on B2
    doReset();
    writeReg(3'd4, 8'h1E);
    for (int t = 0; t < 1700; t++) begin
      bit fsL;
      fsL = (t % 512 == 5 || t % 512 == 6) && t < 1029;
      if (t == 1300 || t == 1301) fsL = 1;
      slaveBit(fsL, 1'b1, 1'b1, 1'b1, 1, "R12 rising-edge lock");
    end
    chk("R13 sticky after missing sync", syncErr, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule